// File: doc/BRIEF.md
# Variable-Step Up/Down Counter

This block keeps an unsigned count that moves by a run-time step value rather than by one. It runs on a free-running system clock. A separate 16-bit stepping word tells it when to act: the count changes only when bit 0 of that word goes from 0 to 1. At each such event the block carries out exactly one operation. Clearing wins over everything else. Loading a preset wins over stepping. Otherwise the direction control picks between adding the step and subtracting it.

The clear, load and direction controls each arrive as a full 16-bit word, and only bit 0 of each is used. All arithmetic is unsigned and wraps modulo 2^W; it does not saturate. An active-low synchronous system reset puts the count back to a power-up value set by a parameter. The block is meant to be driven from a slower stepping signal that is synchronous to the system clock. It serves as a step accumulator or address generator inside a larger datapath.

Top module: `vstep_counter`

## Requirements
- R1: While `rstN` is low at a rising edge of `sysClk`, the count becomes `INIT_COUNT` after that edge.
- R2: The count holds at every `sysClk` edge that does not see a step event. A step event is bit 0 of `stepClkWord` sampled as 1 at this edge after being sampled as 0 at the previous edge. A level held high, a level held low and a 1-to-0 change all leave the count unchanged, whatever the other inputs do.
- R3: At a step event with bit 0 of `clearWord` high, the count becomes 0, whatever the load and direction controls are.
- R4: At a step event with clear low and bit 0 of `loadWord` high, the count takes the value of `presetVal`, whatever the direction control is.
- R5: At a step event with clear and load low and bit 0 of `upWord` high, the count becomes (count + `stepVal`) mod 2^W.
- R6: At a step event with clear, load and bit 0 of `upWord` all low, the count becomes (count - `stepVal`) mod 2^W.
- R7: Bits W-1..1 of `stepClkWord`, `clearWord`, `loadWord` and `upWord` have no effect on the count.
- R8: If bit 0 of `stepClkWord` is already 1 when reset is released, that is not a step event. The first step event after reset needs a 0 to be sampled first.
- R9: The new count is visible at `countOut` right after the `sysClk` edge that sees the step event. Before that edge it still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | System clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset to `INIT_COUNT` |
| stepClkWord | input | W | Stepping word; a 0-to-1 change of bit 0 triggers one operation |
| clearWord | input | W | Bit 0 high: clear the count at the step event |
| loadWord | input | W | Bit 0 high: load `presetVal` at the step event |
| upWord | input | W | Bit 0 high: add the step; low: subtract it |
| presetVal | input | W | Value taken by a load |
| stepVal | input | W | Amount added or subtracted |
| countOut | output | W | Current count |

## Verification
The bench builds the block with W = 16 and INIT_COUNT = 16'h1234. With a non-zero power-up value, a system reset cannot be mistaken for a clear, and a missing reset stands out from a cleared count. The full 16-bit width brings both wrap directions within reach: an add crossing 16'hFFFF and a subtract dropping below 0. It also allows control words whose upper bits are all set while bit 0 is clear.

// File: rtl/vstep_counter_pkg.sv
package vstep_counter_pkg;

  // One strobe per operation; at most one is set in any cycle.
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doAdd;
    logic doSub;
  } ctrlStrobes_t;

  localparam ctrlStrobes_t NO_STROBES = '{doClear: 1'b0, doLoad: 1'b0, doAdd: 1'b0, doSub: 1'b0};

endpackage

// File: rtl/vstep_counter_ctrl.sv
module vstep_counter_ctrl
  import vstep_counter_pkg::*;
(
  input  logic         sysClk,
  input  logic         rstN,
  input  logic         stepBit,
  input  logic         clearBit,
  input  logic         loadBit,
  input  logic         upBit,
  output ctrlStrobes_t strobes
);

  // Last sampled level of the stepping bit. It resets to 1, so a level that
  // is already high when reset is released is not taken as a step event.
  logic prevStep;
  logic stepEvent;

  always_ff @(posedge sysClk) begin
    if (!rstN) prevStep <= 1'b1;
    else       prevStep <= stepBit;
  end

  assign stepEvent = stepBit & ~prevStep;

  // Fixed priority: clear, then load, then direction.
  always_comb begin
    strobes = NO_STROBES;
    if (stepEvent) begin
      if (clearBit)     strobes.doClear = 1'b1;
      else if (loadBit) strobes.doLoad  = 1'b1;
      else if (upBit)   strobes.doAdd   = 1'b1;
      else              strobes.doSub   = 1'b1;
    end
  end

endmodule

// File: rtl/vstep_counter_dp.sv
module vstep_counter_dp
  import vstep_counter_pkg::*;
#(
  parameter int unsigned       W          = 16,
  parameter logic [W-1:0]      INIT_COUNT = '0
) (
  input  logic         sysClk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] presetVal,
  input  logic [W-1:0] stepVal,
  output logic [W-1:0] countOut
);

  logic [W-1:0] countQ;
  logic [W-1:0] operandB;
  logic [W:0]   sumFull;
  logic [W-1:0] nextCount;

  // One shared adder: a subtract adds the inverted step with carry-in 1.
  assign operandB = strobes.doSub ? ~stepVal : stepVal;
  assign sumFull  = {1'b0, countQ} + {1'b0, operandB} + {{W{1'b0}}, strobes.doSub};

  always_comb begin
    nextCount = countQ;
    if (strobes.doClear)                   nextCount = '0;
    else if (strobes.doLoad)               nextCount = presetVal;
    else if (strobes.doAdd | strobes.doSub) nextCount = sumFull[W-1:0];
  end

  always_ff @(posedge sysClk) begin
    if (!rstN) countQ <= INIT_COUNT;
    else       countQ <= nextCount;
  end

  assign countOut = countQ;

endmodule

// File: rtl/vstep_counter.sv
module vstep_counter
  import vstep_counter_pkg::*;
#(
  parameter int unsigned  W          = 16,
  parameter logic [W-1:0] INIT_COUNT = '0
) (
  input  logic         sysClk,
  input  logic         rstN,
  input  logic [W-1:0] stepClkWord,
  input  logic [W-1:0] clearWord,
  input  logic [W-1:0] loadWord,
  input  logic [W-1:0] upWord,
  input  logic [W-1:0] presetVal,
  input  logic [W-1:0] stepVal,
  output logic [W-1:0] countOut
);

  ctrlStrobes_t strobes;

  // Only bit 0 of each control word is used (R7).
  logic unusedHighBits;
  assign unusedHighBits = ^{stepClkWord[W-1:1], clearWord[W-1:1], loadWord[W-1:1], upWord[W-1:1]};

  vstep_counter_ctrl ctrl_i (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .stepBit (stepClkWord[0]),
    .clearBit(clearWord[0]),
    .loadBit (loadWord[0]),
    .upBit   (upWord[0]),
    .strobes (strobes)
  );

  vstep_counter_dp #(
    .W         (W),
    .INIT_COUNT(INIT_COUNT)
  ) dp_i (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .presetVal(presetVal),
    .stepVal  (stepVal),
    .countOut (countOut)
  );

endmodule

// File: rtl/vstep_counter_chk.sv
module vstep_counter_chk #(
  parameter int unsigned  W          = 16,
  parameter logic [W-1:0] INIT_COUNT = '0
) (
  input logic         sysClk,
  input logic         rstN,
  input logic [W-1:0] stepClkWord,
  input logic [W-1:0] clearWord,
  input logic [W-1:0] loadWord,
  input logic [W-1:0] upWord,
  input logic [W-1:0] presetVal,
  input logic [W-1:0] stepVal,
  input logic [W-1:0] countOut
);

  // Observer of the stepping bit, kept from the ports only (R8: starts high).
  logic seenStep;
  logic evt;
  always_ff @(posedge sysClk) begin
    if (!rstN) seenStep <= 1'b1;
    else       seenStep <= stepClkWord[0];
  end
  assign evt = rstN & stepClkWord[0] & ~seenStep;

  // R1
  reset_value_chk: assert property (@(posedge sysClk)
    !rstN |=> countOut == INIT_COUNT);

  // R2
  hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !evt |=> countOut == $past(countOut));

  // R3
  clear_wins_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    evt && clearWord[0] |=> countOut == '0);

  // R4
  load_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    evt && !clearWord[0] && loadWord[0] |=> countOut == $past(presetVal));

  // R5
  add_wrap_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    evt && !clearWord[0] && !loadWord[0] && upWord[0]
    |=> countOut == W'($past(countOut) + $past(stepVal)));

  // R6
  sub_wrap_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    evt && !clearWord[0] && !loadWord[0] && !upWord[0]
    |=> countOut == W'($past(countOut) - $past(stepVal)));

endmodule

bind vstep_counter vstep_counter_chk #(
  .W         (W),
  .INIT_COUNT(INIT_COUNT)
) chk_i (
  .sysClk     (sysClk),
  .rstN       (rstN),
  .stepClkWord(stepClkWord),
  .clearWord  (clearWord),
  .loadWord   (loadWord),
  .upWord     (upWord),
  .presetVal  (presetVal),
  .stepVal    (stepVal),
  .countOut   (countOut)
);

// File: tb/vstep_counter_tb_top.sv
module vstep_counter_tb_top;

  localparam int unsigned  W        = 16;
  localparam logic [W-1:0] INIT_VAL = 16'h1234;
  localparam time          CLK_PERIOD = 10ns;

  logic         sysClk = 1'b0;
  logic         rstN;
  logic [W-1:0] stepClkWord, clearWord, loadWord, upWord, presetVal, stepVal;
  logic [W-1:0] countOut;

  int testsRun = 0;
  int testsFailed = 0;
  logic [W-1:0] expCount;

  always #(CLK_PERIOD/2) sysClk = ~sysClk;

  vstep_counter #(.W(W), .INIT_COUNT(INIT_VAL)) dut_i (
    .sysClk(sysClk), .rstN(rstN), .stepClkWord(stepClkWord),
    .clearWord(clearWord), .loadWord(loadWord), .upWord(upWord),
    .presetVal(presetVal), .stepVal(stepVal), .countOut(countOut)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: countOut=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge sysClk);
  endtask

  // Drives the stepping bit low for one cycle, then high with the given controls.
  task automatic stepOnce(input logic [W-1:0] clr, input logic [W-1:0] ld,
                          input logic [W-1:0] up, input logic [W-1:0] pre,
                          input logic [W-1:0] stp);
    stepClkWord = 16'h0000;
    waitNeg(1);
    clearWord = clr; loadWord = ld; upWord = up; presetVal = pre; stepVal = stp;
    stepClkWord = 16'h0001;
    waitNeg(1);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitNeg(2);
    rstN = 1'b1;
  endtask

  task automatic testResetValue();
    stepClkWord = '0; clearWord = '0; loadWord = '0; upWord = '0;
    presetVal = '0; stepVal = '0;
    doReset();
    check("R1 reset value", countOut, INIT_VAL);
  endtask

  task automatic testHighAtReset();
    stepClkWord = 16'h0001; loadWord = 16'h0001; presetVal = 16'hABCD;
    rstN = 1'b0;
    waitNeg(2);
    rstN = 1'b1;
    waitNeg(3);
    check("R8 high level at reset release", countOut, INIT_VAL);
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'hABCD, 16'h0000);
    check("R8 first event after a low", countOut, 16'hABCD);
  endtask

  task automatic testHold();
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'h0100, 16'h0000);
    expCount = 16'h0100;
    presetVal = 16'h5555; upWord = 16'h0001; loadWord = 16'h0000; stepVal = 16'h0003;
    waitNeg(4);
    check("R2 level held high", countOut, expCount);
    stepClkWord = 16'h0000;
    waitNeg(1);
    check("R2 falling change", countOut, expCount);
    clearWord = 16'h0001;
    waitNeg(3);
    check("R2 level held low", countOut, expCount);
    clearWord = 16'h0000;
  endtask

  task automatic testTiming();
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'h0040, 16'h0000);
    stepClkWord = 16'h0000;
    waitNeg(1);
    upWord = 16'h0001; loadWord = 16'h0000; stepVal = 16'h0002;
    stepClkWord = 16'h0001;
    #1;
    check("R9 before edge", countOut, 16'h0040);
    waitNeg(1);
    check("R9 after edge", countOut, 16'h0042);
  endtask

  task automatic testClear();
    stepOnce(16'h0001, 16'h0001, 16'h0001, 16'h7777, 16'h0009);
    check("R3 clear over load and up", countOut, 16'h0000);
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'h0321, 16'h0000);
    stepOnce(16'h0001, 16'h0000, 16'h0000, 16'h0000, 16'h0005);
    check("R3 clear over subtract", countOut, 16'h0000);
  endtask

  task automatic testLoad();
    stepOnce(16'h0000, 16'h0001, 16'h0001, 16'hBEEF, 16'h0011);
    check("R4 load with up high", countOut, 16'hBEEF);
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'h0F0F, 16'h0011);
    check("R4 load with up low", countOut, 16'h0F0F);
  endtask

  task automatic testAdd();
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'h1000, 16'h0000);
    stepOnce(16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h0234);
    check("R5 plain add", countOut, 16'h1234);
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'hFFF0, 16'h0000);
    stepOnce(16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h0020);
    check("R5 add wraps", countOut, 16'h0010);
  endtask

  task automatic testSub();
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'h0100, 16'h0000);
    stepOnce(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0001);
    check("R6 plain subtract", countOut, 16'h00FF);
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'h0005, 16'h0000);
    stepOnce(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0008);
    check("R6 subtract wraps", countOut, 16'hFFFD);
  endtask

  task automatic testUpperBits();
    stepOnce(16'h0000, 16'h0001, 16'h0000, 16'h0050, 16'h0000);
    // Controls with only the upper bits set act as all low: subtract.
    stepClkWord = 16'hFFFE;
    waitNeg(1);
    clearWord = 16'hFFFE; loadWord = 16'hFFFE; upWord = 16'hFFFE; stepVal = 16'h0010;
    stepClkWord = 16'h0001;
    waitNeg(1);
    check("R7 upper bits of controls ignored", countOut, 16'h0040);
    // Upper bits of the stepping word toggling with bit 0 high: no event.
    stepClkWord = 16'hFFFF;
    waitNeg(1);
    stepClkWord = 16'h8001;
    waitNeg(1);
    check("R7 upper stepping bits ignored", countOut, 16'h0040);
    clearWord = '0; loadWord = '0; upWord = '0;
  endtask

  initial begin
    rstN = 1'b0;
    testResetValue();
    testHighAtReset();
    testHold();
    testTiming();
    testClear();
    testLoad();
    testAdd();
    testSub();
    testUpperBits();
    doReset();
    waitNeg(1);
    check("R1 reset after activity", countOut, INIT_VAL);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule